// File: doc/BRIEF.md
# Up-Counting Compare Timer

This block is a general-purpose up-counting timer reached through a word-indexed register bus with separate read and write strobes. Software picks one of three clock-enable inputs as the count source and sets a 12-bit divider. The counter then advances once per divided tick while the block is enabled. Three compare registers raise match flags when the counter steps onto their value, and a wrap flag is raised when the counter passes its all-ones value. One level interrupt is the OR of the flags gated by their enables.

Two counting modes exist. In free-run mode the counter wraps from all ones to zero. In restart mode the counter returns to zero on the step after it equals compare channel 1. A write to compare channel 1 in restart mode also restarts the count. The reset input clears the whole block. Setting the software-reset control bit clears the status, divider, interrupt enables and counter, and keeps only the low configuration field of the control register.

Top module: `upcount_cmp_timer`

## Requirements
- R1: After the reset input, control, divider, status and interrupt-enable read 0, the counter reads 0, each compare register reads all ones (counter width), and irq is 0.
- R2: A control write (index 0) stores the written word with bits 2, 4 and 10 to 14 forced to 0. Bit 0 enables counting, bits 8:6 select the clock source, and bit 9 selects free-run (1) or restart (0).
- R3: Source code 001 counts on ce_periph, 010 on ce_fast and 100 on ce_slow. Every other code gives no ticks, so the counter holds. With SLOW_ALIAS=1, codes 101 to 111 also select ce_slow.
- R4: The divider (index 1) keeps the low 12 bits written. While enabled, the counter advances once per divider+1 ticks of the selected source. While disabled, the counter holds its value.
- R5: In free-run mode a step from all ones goes to 0 and sets status bit 5.
- R6: In restart mode a step taken while the counter equals compare 1 loads 0 instead of incrementing.
- R7: Status bit k-1 (k = 1..3) is set by the step that makes the counter equal compare register k (index 3+k). Compare registers keep the low counter-width bits written.
- R8: Writing status (index 2) clears each bit written as 1 and leaves the bits written as 0. A flag set in the same cycle as its clear stays set.
- R9: Interrupt enable (index 3) keeps the low 6 bits written. irq is 1 exactly when some status bit and its enable bit are both 1.
- R10: A write to compare 1 in restart mode sets the counter to 0 on that edge. In free-run mode the same write does not disturb the count.
- R11: A control write with bit 15 set stores only bits 8:0 of the masked word. It zeroes status, divider, interrupt enable and the counter, and leaves the compare registers unchanged.
- R12: Index 9 reads the live counter. Indexes 7 and 8 and unmapped indexes read 0. Writes to indexes 7, 8, 9 and unmapped indexes change nothing. rdata is 0 while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_periph | input | 1 | Peripheral-rate count enable (source 001) |
| ce_fast | input | 1 | High-rate count enable (source 010) |
| ce_slow | input | 1 | Slow-rate count enable (source 100) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational while rd_en is high |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong divider phase or a wrong source select shows up on the next read of index 9 as a count that is ahead or behind. It can be seen within one divider period. A bad reload or wrap decision shows up in the counter read on the step right after compare 1 or all ones, and in the status word on that same edge. Status ordering faults, such as a clear winning over a set or the wrong bit being cleared, show up on irq and in the status read one edge after the write.

// File: rtl/tct_pkg.sv
package tct_pkg;
   localparam int DATA_W  = 32;
   localparam int NUM_CMP = 3;
   localparam int STAT_W  = 6;

   localparam int REG_CTRL = 0;
   localparam int REG_PRE  = 1;
   localparam int REG_STAT = 2;
   localparam int REG_IE   = 3;
   localparam int REG_CMP1 = 4;
   localparam int REG_CAP1 = 7;
   localparam int REG_CAP2 = 8;
   localparam int REG_CNT  = 9;

   localparam logic [DATA_W-1:0] CTRL_ZERO_MASK = 32'h0000_7C14;
   localparam logic [DATA_W-1:0] CTRL_SOFT_KEEP = 32'h0000_01FF;

   localparam int CB_EN     = 0;
   localparam int CB_SRC_LO = 6;
   localparam int CB_FREE   = 9;
   localparam int CB_SOFT   = 15;
   localparam int SB_ROLL   = 5;

   typedef enum logic [2:0] {
      SRC_OFF    = 3'b000,
      SRC_PERIPH = 3'b001,
      SRC_FAST   = 3'b010,
      SRC_SLOW   = 3'b100
   } src_t;
endpackage

// File: rtl/tct_clksel.sv
module tct_clksel
   import tct_pkg::*;
#(
   parameter bit SLOW_ALIAS = 1'b0
) (
   input  logic [2:0] src,
   input  logic       ce_periph,
   input  logic       ce_fast,
   input  logic       ce_slow,
   output logic       tick
);
   generate
      if (SLOW_ALIAS) begin : g_alias
         always_comb begin
            case (src)
               SRC_PERIPH:                      tick = ce_periph;
               SRC_FAST:                        tick = ce_fast;
               3'b100, 3'b101, 3'b110, 3'b111:  tick = ce_slow;
               default:                         tick = 1'b0;
            endcase
         end
      end else begin : g_strict
         always_comb begin
            case (src)
               SRC_PERIPH: tick = ce_periph;
               SRC_FAST:   tick = ce_fast;
               SRC_SLOW:   tick = ce_slow;
               default:    tick = 1'b0;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/tct_prescale.sv
module tct_prescale #(
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             clr,
   input  logic [PRE_W-1:0] pre,
   output logic             step
);
   logic [PRE_W-1:0] phase_q;
   logic             phase_end;

   assign phase_end = (phase_q == pre);
   assign step      = en && tick && phase_end && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (clr || !en) begin
         phase_q <= '0;
      end else if (tick) begin
         phase_q <= phase_end ? '0 : phase_q + PRE_W'(1);
      end
   end

   // R4: the phase never runs past the divider value
   a_r4_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q <= pre);
endmodule

// File: rtl/tct_counter.sv
module tct_counter #(
   parameter int CNT_W   = 32,
   parameter int NUM_CMP = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     step,
   input  logic                     restart_mode,
   input  logic                     zero_load,
   input  logic [NUM_CMP*CNT_W-1:0] cmp_flat,
   output logic [CNT_W-1:0]         cnt,
   output logic [NUM_CMP-1:0]       match,
   output logic                     rollover
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt;
   logic             reload;
   logic             adv;

   assign reload = restart_mode && (cnt_q == cmp_flat[CNT_W-1:0]);
   assign nxt    = reload ? '0 : cnt_q + CNT_W'(1);
   assign adv    = step && !zero_load;
   assign cnt    = cnt_q;

   generate
      for (genvar k = 0; k < NUM_CMP; k++) begin : g_match
         assign match[k] = adv && (nxt == cmp_flat[k*CNT_W +: CNT_W]);
      end
   endgenerate

   assign rollover = adv && (&cnt_q) && !reload;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (zero_load) cnt_q <= '0;
      else if (step)      cnt_q <= nxt;
   end

   // R4: no step, no change
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !zero_load) |=> $stable(cnt_q));
   // R6: restart-mode reload on channel-1 equality
   a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (step && restart_mode && cnt_q == cmp_flat[CNT_W-1:0]) |=> cnt_q == '0);
   // R5: wrap lands on zero
   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rollover |=> cnt_q == '0);
   // R10: forced restart wins over a step
   a_r10_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
      zero_load |=> cnt_q == '0);
endmodule

// File: rtl/tct_regs.sv
module tct_regs
   import tct_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int PRE_W  = 12,
   parameter int ADDR_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   output logic [DATA_W-1:0]        rdata,
   input  logic [CNT_W-1:0]         cnt,
   input  logic [NUM_CMP-1:0]       match,
   input  logic                     rollover,
   output logic                     run_en,
   output logic [2:0]               src,
   output logic                     free_run,
   output logic [PRE_W-1:0]         pre,
   output logic [NUM_CMP*CNT_W-1:0] cmp_flat,
   output logic                     zero_load,
   output logic                     phase_clr,
   output logic                     irq
);
   logic [DATA_W-1:0] ctrl_q;
   logic [PRE_W-1:0]  pre_q;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] ie_q;
   logic [STAT_W-1:0] set_vec;
   logic [STAT_W-1:0] clr_vec;
   logic [DATA_W-1:0] ctrl_w;
   logic [DATA_W-1:0] cnt_ext;
   logic [DATA_W-1:0] pre_ext;
   logic [DATA_W-1:0] cmp_ext [NUM_CMP];
   logic              wr_ctrl, wr_pre, wr_stat, wr_ie, wr_cmp1, soft_wr;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
      return a == ADDR_W'(idx);
   endfunction

   assign wr_ctrl = wr_en && hit(addr, REG_CTRL);
   assign wr_pre  = wr_en && hit(addr, REG_PRE);
   assign wr_stat = wr_en && hit(addr, REG_STAT);
   assign wr_ie   = wr_en && hit(addr, REG_IE);
   assign wr_cmp1 = wr_en && hit(addr, REG_CMP1);
   assign soft_wr = wr_ctrl && wdata[CB_SOFT];
   assign ctrl_w  = wdata & ~CTRL_ZERO_MASK;

   always_comb begin
      set_vec = '0;
      set_vec[NUM_CMP-1:0] = match;
      set_vec[SB_ROLL]     = rollover;
      clr_vec = wr_stat ? wdata[STAT_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= soft_wr ? (ctrl_w & CTRL_SOFT_KEEP) : ctrl_w;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         ie_q   <= '0;
         stat_q <= '0;
      end else if (soft_wr) begin
         pre_q  <= '0;
         ie_q   <= '0;
         stat_q <= '0;
      end else begin
         if (wr_pre) pre_q <= wdata[PRE_W-1:0];
         if (wr_ie)  ie_q  <= wdata[STAT_W-1:0];
         stat_q <= (stat_q & ~clr_vec) | set_vec;
      end
   end

   generate
      for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
         logic [CNT_W-1:0] cmp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cmp_q <= '1;
            else if (wr_en && hit(addr, REG_CMP1 + k)) cmp_q <= wdata[CNT_W-1:0];
         end
         assign cmp_flat[k*CNT_W +: CNT_W] = cmp_q;
         always_comb begin
            cmp_ext[k] = '0;
            cmp_ext[k][CNT_W-1:0] = cmp_q;
         end
      end
   endgenerate

   always_comb begin
      cnt_ext = '0;
      cnt_ext[CNT_W-1:0] = cnt;
      pre_ext = '0;
      pre_ext[PRE_W-1:0] = pre_q;
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (hit(addr, REG_CTRL))      rdata = ctrl_q;
         else if (hit(addr, REG_PRE))  rdata = pre_ext;
         else if (hit(addr, REG_STAT)) rdata = {{(DATA_W-STAT_W){1'b0}}, stat_q};
         else if (hit(addr, REG_IE))   rdata = {{(DATA_W-STAT_W){1'b0}}, ie_q};
         else if (hit(addr, REG_CNT))  rdata = cnt_ext;
         else begin
            for (int k = 0; k < NUM_CMP; k++) begin
               if (hit(addr, REG_CMP1 + k)) rdata = cmp_ext[k];
            end
         end
      end
   end

   assign run_en    = ctrl_q[CB_EN];
   assign src       = ctrl_q[CB_SRC_LO +: 3];
   assign free_run  = ctrl_q[CB_FREE];
   assign pre       = pre_q;
   assign zero_load = soft_wr || (wr_cmp1 && !ctrl_q[CB_FREE]);
   assign phase_clr = zero_load || wr_pre;
   assign irq       = |(stat_q & ie_q);

   // R8: a flag not written with 1 stays set
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !soft_wr |=> (($past(stat_q) & ~$past(clr_vec)) & ~stat_q) == '0);
   // R11: software reset clears the side registers
   a_r11_soft_clears: assert property (@(posedge clk) disable iff (!rst_n)
      soft_wr |=> (stat_q == '0 && pre_q == '0 && ie_q == '0 && !ctrl_q[CB_SOFT]));
   // R9: interrupt only with some enable set
   a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ie_q != '0);
endmodule

// File: rtl/upcount_cmp_timer.sv
module upcount_cmp_timer
   import tct_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int PRE_W      = 12,
   parameter int ADDR_W     = 4,
   parameter bit SLOW_ALIAS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_periph,
   input  logic              ce_fast,
   input  logic              ce_slow,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq
);
   localparam int CMP_BITS = NUM_CMP * CNT_W;

   initial begin
      a_cfg_cnt_w: assert (CNT_W >= 2 && CNT_W <= DATA_W)
         else $error("CNT_W out of range");
      a_cfg_pre_w: assert (PRE_W >= 1 && PRE_W <= DATA_W)
         else $error("PRE_W out of range");
      a_cfg_addr_w: assert (ADDR_W >= 4)
         else $error("ADDR_W too small for the register map");
   end

   logic                run_en, free_run, zero_load, phase_clr, tick, step, rollover;
   logic [2:0]          src;
   logic [PRE_W-1:0]    pre;
   logic [CMP_BITS-1:0] cmp_flat;
   logic [CNT_W-1:0]    cnt;
   logic [NUM_CMP-1:0]  match;

   tct_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .cnt(cnt), .match(match), .rollover(rollover),
      .run_en(run_en), .src(src), .free_run(free_run), .pre(pre),
      .cmp_flat(cmp_flat), .zero_load(zero_load), .phase_clr(phase_clr), .irq(irq)
   );

   tct_clksel #(.SLOW_ALIAS(SLOW_ALIAS)) u_clksel (
      .src(src), .ce_periph(ce_periph), .ce_fast(ce_fast), .ce_slow(ce_slow),
      .tick(tick)
   );

   tct_prescale #(.PRE_W(PRE_W)) u_prescale (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(run_en), .clr(phase_clr),
      .pre(pre), .step(step)
   );

   tct_counter #(.CNT_W(CNT_W), .NUM_CMP(NUM_CMP)) u_counter (
      .clk(clk), .rst_n(rst_n), .step(step), .restart_mode(!free_run),
      .zero_load(zero_load), .cmp_flat(cmp_flat), .cnt(cnt), .match(match),
      .rollover(rollover)
   );

   // R4: a disabled timer never steps
   a_r4_no_step_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !step);
endmodule

// File: tb/test_upcount_cmp_timer.sv
module test_upcount_cmp_timer;
   localparam int CLK_PERIOD = 10;
   localparam int CW         = 10;
   localparam int AW         = 4;
   localparam int WATCHDOG   = 200000;
   localparam logic [31:0] CMAX = 32'h3FF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_periph = 1'b1, ce_fast = 1'b0, ce_slow = 1'b0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   upcount_cmp_timer #(.CNT_W(CW), .ADDR_W(AW)) i_upcount_cmp_timer (
      .clk(clk), .rst_n(rst_n), .ce_periph(ce_periph), .ce_fast(ce_fast),
      .ce_slow(ce_slow), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hard_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
   endtask

   task automatic bus_wr(input int a, input logic [31:0] d);
      addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input string what, input int a,
                         input logic [31:0] exp);
      logic [31:0] d;
      addr = AW'(a); rd_en = 1'b1;
      #1;
      d = rdata;
      rd_en = 1'b0;
      check(req, what, d, exp);
   endtask

   task automatic t_reset_values();
      hard_reset();
      rd_chk("R1", "ctrl", 0, 32'h0);
      rd_chk("R1", "prescale", 1, 32'h0);
      rd_chk("R1", "status", 2, 32'h0);
      rd_chk("R1", "int enable", 3, 32'h0);
      rd_chk("R1", "cmp1", 4, CMAX);
      rd_chk("R1", "cmp2", 5, CMAX);
      rd_chk("R1", "cmp3", 6, CMAX);
      rd_chk("R1", "count", 9, 32'h0);
      check("R1", "irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_masks_and_soft_reset();
      hard_reset();
      bus_wr(0, 32'hFFFF_7FFF);
      rd_chk("R2", "ctrl masked", 0, 32'hFFFF_03EB);
      bus_wr(1, 32'hFFFF_F123);
      rd_chk("R4", "prescale width", 1, 32'h123);
      bus_wr(3, 32'hFFFF_FFFF);
      rd_chk("R9", "int enable width", 3, 32'h3F);
      bus_wr(5, 32'h000A_BCDE);
      rd_chk("R7", "cmp2 width", 5, 32'h0DE);
      rd_chk("R3", "source 111 no count", 9, 32'h0);
      bus_wr(0, 32'hFFFF_FFFF);
      rd_chk("R11", "ctrl after soft reset", 0, 32'h1EB);
      rd_chk("R11", "prescale cleared", 1, 32'h0);
      rd_chk("R11", "int enable cleared", 3, 32'h0);
      rd_chk("R11", "status cleared", 2, 32'h0);
      rd_chk("R11", "cmp2 kept", 5, 32'h0DE);
      rd_chk("R11", "count zero", 9, 32'h0);
   endtask

   task automatic t_prescale();
      hard_reset();
      bus_wr(1, 32'd3);
      bus_wr(0, 32'h241);
      idle(11);
      rd_chk("R4", "divide by 4 after 11", 9, 32'd2);
      idle(1);
      rd_chk("R4", "divide by 4 after 12", 9, 32'd3);
      bus_wr(0, 32'h240);
      idle(10);
      rd_chk("R4", "hold while disabled", 9, 32'd3);
      bus_wr(0, 32'h241);
      idle(4);
      rd_chk("R4", "resume", 9, 32'd4);
   endtask

   task automatic t_free_run_wrap();
      hard_reset();
      bus_wr(0, 32'h241);
      idle(1022);
      rd_chk("R5", "count before top", 9, 32'd1022);
      rd_chk("R5", "no flags yet", 2, 32'h0);
      idle(1);
      rd_chk("R5", "count at top", 9, CMAX);
      rd_chk("R7", "all-ones compares matched", 2, 32'h07);
      idle(1);
      rd_chk("R5", "count wrapped", 9, 32'h0);
      rd_chk("R5", "wrap flag", 2, 32'h27);
   endtask

   task automatic t_restart();
      hard_reset();
      bus_wr(4, 32'd5);
      bus_wr(0, 32'h041);
      idle(5);
      rd_chk("R6", "count at cmp1", 9, 32'd5);
      rd_chk("R7", "cmp1 flag", 2, 32'h01);
      idle(1);
      rd_chk("R6", "reload to zero", 9, 32'd0);
      idle(5);
      rd_chk("R6", "second period", 9, 32'd5);
      idle(1);
      rd_chk("R6", "second reload", 9, 32'd0);
      rd_chk("R5", "no wrap flag in restart", 2, 32'h01);
   endtask

   task automatic t_match_irq_w1c();
      hard_reset();
      bus_wr(5, 32'd4);
      bus_wr(6, 32'd20);
      bus_wr(3, 32'h02);
      bus_wr(0, 32'h241);
      idle(3);
      rd_chk("R7", "no match at 3", 2, 32'h0);
      check("R9", "irq low", {31'b0, irq}, 32'h0);
      idle(1);
      rd_chk("R7", "cmp2 match", 2, 32'h02);
      check("R9", "irq high", {31'b0, irq}, 32'h1);
      bus_wr(2, 32'h01);
      rd_chk("R8", "write 0 keeps flag", 2, 32'h02);
      bus_wr(2, 32'h02);
      rd_chk("R8", "write 1 clears", 2, 32'h0);
      check("R9", "irq after clear", {31'b0, irq}, 32'h0);
      idle(13);
      bus_wr(2, 32'h04);
      rd_chk("R8", "set wins over clear", 2, 32'h04);
      check("R9", "masked flag no irq", {31'b0, irq}, 32'h0);
      bus_wr(3, 32'h04);
      check("R9", "enable raises irq", {31'b0, irq}, 32'h1);
      bus_wr(3, 32'h00);
      check("R9", "disable drops irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_clock_select();
      hard_reset();
      bus_wr(0, 32'h301);
      idle(5);
      rd_chk("R3", "slow source idle", 9, 32'd0);
      ce_slow = 1'b1;
      idle(5);
      rd_chk("R3", "slow source ticking", 9, 32'd5);
      ce_fast = 1'b1;
      bus_wr(0, 32'h2C1);
      idle(5);
      rd_chk("R3", "code 011 no clock", 9, 32'd6);
      bus_wr(0, 32'h281);
      idle(4);
      rd_chk("R3", "fast source", 9, 32'd10);
      ce_fast = 1'b0;
      idle(3);
      rd_chk("R3", "fast source idle", 9, 32'd10);
      ce_fast = 1'b1;
      bus_wr(0, 32'h201);
      idle(3);
      rd_chk("R3", "code 000 no clock", 9, 32'd11);
      ce_fast = 1'b0;
      ce_slow = 1'b0;
   endtask

   task automatic t_cmp1_write();
      hard_reset();
      bus_wr(4, 32'd100);
      bus_wr(0, 32'h041);
      idle(10);
      rd_chk("R10", "before cmp1 write", 9, 32'd10);
      bus_wr(4, 32'd200);
      rd_chk("R10", "restart on cmp1 write", 9, 32'd0);
      idle(3);
      rd_chk("R10", "counting after restart", 9, 32'd3);
      bus_wr(0, 32'h241);
      bus_wr(4, 32'd300);
      rd_chk("R10", "free-run cmp1 write no restart", 9, 32'd5);
   endtask

   task automatic t_ignored();
      hard_reset();
      bus_wr(0, 32'h241);
      idle(7);
      bus_wr(0, 32'h240);
      bus_wr(9, 32'h55);
      rd_chk("R12", "count write ignored", 9, 32'd8);
      bus_wr(7, 32'h1234);
      rd_chk("R12", "capture1 reads 0", 7, 32'h0);
      rd_chk("R12", "capture2 reads 0", 8, 32'h0);
      bus_wr(12, 32'hFFFF_FFFF);
      rd_chk("R12", "unmapped reads 0", 12, 32'h0);
      rd_chk("R12", "ctrl untouched", 0, 32'h240);
      rd_chk("R12", "prescale untouched", 1, 32'h0);
      rd_chk("R12", "int enable untouched", 3, 32'h0);
      addr = AW'(0); rd_en = 1'b0;
      #1;
      check("R12", "rdata idle zero", rdata, 32'h0);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   initial begin
      t_reset_values();
      t_masks_and_soft_reset();
      t_prescale();
      t_free_run_wrap();
      t_restart();
      t_match_irq_w1c();
      t_clock_select();
      t_cmp1_write();
      t_ignored();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog run did not finish actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
         summary();
         $finish;
      end
   end
endmodule